// File: doc/BRIEF.md
# Per-Interface Outbound Message Packer

This block sits between one component's outbound interface and the send driver of one physical channel. The component streams payload words in with a valid/ready handshake. Along with the first payload word it supplies the destination processor, the destination component, the message kind (request or response), the response-required flag and, for a response, a reply status. The packer stores the payload in a single buffer stage until the final payload word arrives. It then emits a complete message: a sectioned address header, then the payload, on a valid/ready word stream.

The source processor address, the source component address and the interface command are elaboration-time parameters. Each interface has its own packer, so no address lookup is needed. The whole-message length in words is known only when the payload has ended. For that reason no header word leaves the block before the last payload word has been accepted. A payload longer than the buffer is cut to the buffer depth, and the message that results is flagged.

Top module: `req_msg_packer`

## Requirements
- R1: Output word 0 of every message is {dstProc[31:24], SRC_PROC[23:16], dstComp[15:8], kind[7], needResponse[6], zero[5:0]}, where kind is 0 for a request and 1 for a response.
- R2: Output word 1 is {SRC_COMP[31:24], CMD[23:16], length[15:0]}, where length is the total number of output words of the message, header included.
- R3: A response message carries its reply status, zero-extended, as word 2, and its payload starts at word 3. A request has no status word, and its payload starts at word 2.
- R4: Stored payload words follow the header in arrival order. outLast is high on the final word of the message and on no other word.
- R5: No output word is offered (outValid low) until the payload word marked inLast has been accepted. While a message is being emitted, inReady is low.
- R6: While outValid is high and outReady is low, outValid, outData, outLast and outTrunc hold their values into the next cycle.
- R7: Only the first DEPTH (default 64) payload words are stored. Further words are accepted and dropped, the length covers only the stored words, and outTrunc is high on every output word of that message. It is low on every word of a message that fits.
- R8: After reset, outValid and outTrunc are low and inReady is high.
- R9: dstProc, dstComp, isResponse, needResponse and replyStatus are sampled together with the first payload word. Later changes to them before the next message have no effect on the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Payload word offered |
| inReady | output | 1 | Packer accepts payload words |
| inData | input | 32 | Payload word |
| inLast | input | 1 | Final payload word of the message |
| dstProc | input | 8 | Destination processor, sampled with first word |
| dstComp | input | 8 | Destination component, sampled with first word |
| isResponse | input | 1 | 1 = response message, 0 = request |
| needResponse | input | 1 | Requester wants a response |
| replyStatus | input | 8 | Exception status for a response |
| outValid | output | 1 | Message word offered |
| outReady | input | 1 | Channel driver accepts the word |
| outData | output | 32 | Message word |
| outLast | output | 1 | Final word of the message |
| outTrunc | output | 1 | Current message lost payload words to truncation |

## Verification
The bench aims at the buffer edges: one payload word, exactly DEPTH words, DEPTH+1 words and a payload well past the depth. A packer with an off-by-one count would drop or repeat a word, state a wrong length, or raise outTrunc on a payload that fits. Response and request messages are mixed so that a status word placed wrongly or left out shows up as shifted payload and a wrong length. The sideband inputs are scrambled after the first word, which exposes a design that samples them late. Random stalls on outReady catch data that changes or is skipped under back-pressure.

// File: rtl/req_msg_packer_pkg.sv
package req_msg_packer_pkg;

  typedef enum logic {
    ST_FILL = 1'b0,
    ST_EMIT = 1'b1
  } packState_e;

  typedef enum logic [1:0] {
    SEL_HDR0 = 2'd0,
    SEL_HDR1 = 2'd1,
    SEL_STAT = 2'd2,
    SEL_PAY  = 2'd3
  } wordSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     wrEn;      // store the accepted payload word
    logic     capHdr;    // first word: latch sideband fields
    logic     setTrunc;  // a word was dropped past the buffer depth
    wordSel_e sel;       // which word the output mux presents
  } packCtl_t;

endpackage

// File: rtl/req_msg_packer_ctrl.sv
module req_msg_packer_ctrl
  import req_msg_packer_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = $clog2(DEPTH + 4),
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  input  logic             respMode,
  input  logic             outReady,
  output logic             outValid,
  output logic             outLast,
  output packCtl_t         ctl,
  output logic [CNT_W-1:0] payCnt,
  output logic [AW-1:0]    wrAddr,
  output logic [AW-1:0]    rdAddr
);

  packState_e       state;
  logic [IDX_W-1:0] emitIdx;
  logic [IDX_W-1:0] hdrWords;
  logic [IDX_W-1:0] totalWords;
  logic [IDX_W-1:0] rdOff;
  logic             accept;
  logic             bufFull;

  assign inReady    = (state == ST_FILL);
  assign outValid   = (state == ST_EMIT);
  assign accept     = inValid && inReady;
  assign bufFull    = (payCnt == CNT_W'(DEPTH));
  assign hdrWords   = respMode ? IDX_W'(3) : IDX_W'(2);
  assign totalWords = hdrWords + IDX_W'(payCnt);
  assign outLast    = outValid && (emitIdx == totalWords - IDX_W'(1));
  assign rdOff      = emitIdx - hdrWords;
  assign rdAddr     = rdOff[AW-1:0];
  assign wrAddr     = payCnt[AW-1:0];

  always_comb begin
    ctl.wrEn     = accept && !bufFull;
    ctl.capHdr   = accept && (payCnt == '0);
    ctl.setTrunc = accept && bufFull;
    if (emitIdx == IDX_W'(0))                  ctl.sel = SEL_HDR0;
    else if (emitIdx == IDX_W'(1))             ctl.sel = SEL_HDR1;
    else if (emitIdx == IDX_W'(2) && respMode) ctl.sel = SEL_STAT;
    else                                       ctl.sel = SEL_PAY;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_FILL;
      payCnt  <= '0;
      emitIdx <= '0;
    end else begin
      case (state)
        ST_FILL: begin
          if (accept) begin
            if (!bufFull) payCnt <= payCnt + CNT_W'(1);
            if (inLast) begin
              state   <= ST_EMIT;
              emitIdx <= '0;
            end
          end
        end
        ST_EMIT: begin
          if (outReady) begin
            if (outLast) begin
              state   <= ST_FILL;
              payCnt  <= '0;
              emitIdx <= '0;
            end else begin
              emitIdx <= emitIdx + IDX_W'(1);
            end
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end

endmodule

// File: rtl/req_msg_packer_dp.sv
module req_msg_packer_dp
  import req_msg_packer_pkg::*;
#(
  parameter int         DEPTH    = 64,
  parameter int         CNT_W    = $clog2(DEPTH + 1),
  parameter int         AW       = $clog2(DEPTH),
  parameter logic [7:0] SRC_PROC = 8'h11,
  parameter logic [7:0] SRC_COMP = 8'h22,
  parameter logic [7:0] CMD      = 8'h33
) (
  input  logic             clk,
  input  logic             rstN,
  input  packCtl_t         ctl,
  input  logic [CNT_W-1:0] payCnt,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [31:0]      inData,
  input  logic [7:0]       dstProc,
  input  logic [7:0]       dstComp,
  input  logic             isResponse,
  input  logic             needResponse,
  input  logic [7:0]       replyStatus,
  input  logic             outValid,
  output logic             respMode,
  output logic [31:0]      outData,
  output logic             outTrunc
);

  logic [31:0] payMem [DEPTH];
  logic [7:0]  dstProcQ;
  logic [7:0]  dstCompQ;
  logic        needRespQ;
  logic [7:0]  statQ;
  logic        truncQ;
  logic [15:0] msgLen;
  logic [31:0] hdr0;
  logic [31:0] hdr1;

  always_ff @(posedge clk) begin
    if (ctl.wrEn) payMem[wrAddr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstProcQ  <= '0;
      dstCompQ  <= '0;
      respMode  <= 1'b0;
      needRespQ <= 1'b0;
      statQ     <= '0;
      truncQ    <= 1'b0;
    end else begin
      if (ctl.capHdr) begin
        dstProcQ  <= dstProc;
        dstCompQ  <= dstComp;
        respMode  <= isResponse;
        needRespQ <= needResponse;
        statQ     <= replyStatus;
        truncQ    <= 1'b0;
      end else if (ctl.setTrunc) begin
        truncQ    <= 1'b1;
      end
    end
  end

  assign msgLen = 16'(payCnt) + (respMode ? 16'd3 : 16'd2);
  assign hdr0   = {dstProcQ, SRC_PROC, dstCompQ, respMode, needRespQ, 6'b0};
  assign hdr1   = {SRC_COMP, CMD, msgLen};

  always_comb begin
    case (ctl.sel)
      SEL_HDR0: outData = hdr0;
      SEL_HDR1: outData = hdr1;
      SEL_STAT: outData = {24'b0, statQ};
      default:  outData = payMem[rdAddr];
    endcase
  end

  assign outTrunc = truncQ && outValid;

endmodule

// File: rtl/req_msg_packer.sv
module req_msg_packer
  import req_msg_packer_pkg::*;
#(
  parameter int         DEPTH    = 64,
  parameter logic [7:0] SRC_PROC = 8'h11,
  parameter logic [7:0] SRC_COMP = 8'h22,
  parameter logic [7:0] CMD      = 8'h33
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] inData,
  input  logic        inLast,
  input  logic [7:0]  dstProc,
  input  logic [7:0]  dstComp,
  input  logic        isResponse,
  input  logic        needResponse,
  input  logic [7:0]  replyStatus,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] outData,
  output logic        outLast,
  output logic        outTrunc
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH + 4);
  localparam int AW    = $clog2(DEPTH);

  packCtl_t         ctl;
  logic [CNT_W-1:0] payCnt;
  logic [AW-1:0]    wrAddr;
  logic [AW-1:0]    rdAddr;
  logic             respMode;

  req_msg_packer_ctrl #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W), .AW(AW)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .respMode(respMode),
    .outReady(outReady), .outValid(outValid), .outLast(outLast),
    .ctl(ctl), .payCnt(payCnt), .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  req_msg_packer_dp #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .AW(AW),
    .SRC_PROC(SRC_PROC), .SRC_COMP(SRC_COMP), .CMD(CMD)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .ctl(ctl), .payCnt(payCnt), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inData(inData), .dstProc(dstProc), .dstComp(dstComp),
    .isResponse(isResponse), .needResponse(needResponse),
    .replyStatus(replyStatus), .outValid(outValid),
    .respMode(respMode), .outData(outData), .outTrunc(outTrunc)
  );

endmodule

// File: rtl/req_msg_packer_chk.sv
module req_msg_packer_chk #(
  parameter logic [7:0] SRC_PROC = 8'h11,
  parameter logic [7:0] SRC_COMP = 8'h22,
  parameter logic [7:0] CMD      = 8'h33
) (
  input logic        clk,
  input logic        rstN,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outData,
  input logic        outLast,
  input logic        outTrunc
);

  // position of the current output word within its message
  logic [7:0] beatIdx;
  always_ff @(posedge clk) begin
    if (!rstN) beatIdx <= '0;
    else if (outValid && outReady) begin
      if (outLast)                beatIdx <= '0;
      else if (beatIdx != 8'hFF)  beatIdx <= beatIdx + 8'd1;
    end
  end

  p_hdr0_fields_r1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && beatIdx == 8'd0) |-> (outData[23:16] == SRC_PROC && outData[5:0] == 6'b0));

  p_hdr1_fields_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && beatIdx == 8'd1) |->
      (outData[31:24] == SRC_COMP && outData[23:16] == CMD && outData[15:0] >= 16'd3));

  p_last_at_length_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast) |-> beatIdx >= 8'd2);

  p_last_needs_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  p_no_input_while_emit_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=>
      (outValid && $stable(outData) && $stable(outLast) && $stable(outTrunc)));

  p_trunc_steady_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !(outReady && outLast)) |=> (outTrunc == $past(outTrunc)));

  p_trunc_needs_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    outTrunc |-> outValid);

endmodule

bind req_msg_packer req_msg_packer_chk #(
  .SRC_PROC(SRC_PROC), .SRC_COMP(SRC_COMP), .CMD(CMD)
) chk_i (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .outData(outData), .outLast(outLast), .outTrunc(outTrunc)
);

// File: tb/req_msg_packer_tb.sv
module req_msg_packer_tb_top;

  localparam int         DEPTH    = 64;
  localparam logic [7:0] SRC_PROC = 8'h11;
  localparam logic [7:0] SRC_COMP = 8'h22;
  localparam logic [7:0] CMD      = 8'h33;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inData = '0;
  logic        inLast = 1'b0;
  logic [7:0]  dstProc = '0;
  logic [7:0]  dstComp = '0;
  logic        isResponse = 1'b0;
  logic        needResponse = 1'b0;
  logic [7:0]  replyStatus = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] outData;
  logic        outLast;
  logic        outTrunc;

  int tests = 0;
  int fails = 0;

  logic [31:0] payload [0:127];
  logic [31:0] expW    [0:127];
  int          expN;

  always #4 clk = ~clk;  // 125 MHz

  req_msg_packer #(
    .DEPTH(DEPTH), .SRC_PROC(SRC_PROC), .SRC_COMP(SRC_COMP), .CMD(CMD)
  ) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .dstProc(dstProc), .dstComp(dstComp),
    .isResponse(isResponse), .needResponse(needResponse),
    .replyStatus(replyStatus), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outLast(outLast), .outTrunc(outTrunc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // expected message from the requirements
  function automatic void buildExp(input int nPay, input logic [7:0] dp, input logic [7:0] dc,
                                   input logic rsp, input logic nr, input logic [7:0] st);
    int stored = (nPay > DEPTH) ? DEPTH : nPay;
    int hdr    = rsp ? 3 : 2;
    expN    = hdr + stored;
    expW[0] = {dp, SRC_PROC, dc, rsp, nr, 6'b0};          // R1
    expW[1] = {SRC_COMP, CMD, 16'(expN)};                 // R2
    if (rsp) expW[2] = {24'b0, st};                       // R3
    for (int i = 0; i < stored; i++) expW[hdr + i] = payload[i];  // R4
  endfunction

  task automatic runMsg(input int nPay, input logic rsp, input bit stallOut);
    logic [7:0] dp = 8'($urandom);
    logic [7:0] dc = 8'($urandom);
    logic       nr = 1'($urandom);
    logic [7:0] st = 8'($urandom);
    bit earlyOut = 0;
    bit truncExp = (nPay > DEPTH);
    for (int i = 0; i < nPay; i++) payload[i] = $urandom;
    buildExp(nPay, dp, dc, rsp, nr, st);
    // fill phase
    for (int i = 0; i < nPay; i++) begin
      @(negedge clk);
      if (i == 0) begin
        dstProc = dp; dstComp = dc; isResponse = rsp; needResponse = nr; replyStatus = st;
      end
      if (outValid) earlyOut = 1;
      inValid = 1'b1; inData = payload[i]; inLast = (i == nPay - 1);
      @(posedge clk);
      #1;
      inValid = 1'b0; inLast = 1'b0;
      // R9: scramble sideband after the first word
      dstProc = 8'($urandom); dstComp = 8'($urandom); isResponse = 1'($urandom);
      needResponse = 1'($urandom); replyStatus = 8'($urandom);
      if (i != nPay - 1) begin
        repeat ($urandom_range(0, 1)) begin
          @(negedge clk);
          if (outValid) earlyOut = 1;
        end
      end
    end
    check("R5 no output before last input", 32'(earlyOut), 32'd0);
    @(negedge clk);
    check("R5 inReady low while emitting", 32'(inReady), 32'd0);
    // emit phase
    for (int k = 0; k < expN; k++) begin
      int stall = stallOut ? int'($urandom_range(0, 2)) : 0;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        outReady = 1'b0;
        check("R6 valid held under stall", 32'(outValid), 32'd1);
        check("R6 data held under stall", outData, expW[k]);
        @(posedge clk);
      end
      @(negedge clk);
      check("R1/R2/R3/R4/R9 word", outData, expW[k]);
      check("R4 outLast position", 32'(outLast), 32'(k == expN - 1));
      check("R7 outTrunc", 32'(outTrunc), 32'(truncExp));
      outReady = 1'b1;
      @(posedge clk);
      #1;
      outReady = 1'b0;
    end
    @(negedge clk);
    check("R5 inReady back after message", 32'(inReady), 32'd1);
    check("R5 outValid low after message", 32'(outValid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R8 reset outValid", 32'(outValid), 32'd0);
    check("R8 reset outTrunc", 32'(outTrunc), 32'd0);
    check("R8 reset inReady", 32'(inReady), 32'd1);
    // directed corners
    runMsg(1,  1'b0, 1'b0);   // single word request
    runMsg(1,  1'b1, 1'b1);   // single word response
    runMsg(DEPTH, 1'b1, 1'b1);     // exactly full
    runMsg(DEPTH + 1, 1'b0, 1'b1); // one word over, R7
    runMsg(DEPTH + 7, 1'b1, 1'b0); // well past, R7
    runMsg(3,  1'b0, 1'b1);   // fits again: outTrunc must clear, R7
    // random mix
    for (int m = 0; m < 14; m++)
      runMsg(int'($urandom_range(1, DEPTH + 3)), 1'($urandom), 1'b1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule